// File: doc/BRIEF.md
# Dual-Compare Timer/Counter

An 8-bit timer/counter with two compare channels and a small register file on a simple write/read bus. Its count advances on a tick. The tick is chosen by a 3-bit source field. The source can be stopped, one of five prescaler strobes supplied from outside the block, or either edge of an external pin that is synchronized inside the block. Four counting modes are available. In free-run mode the counter counts up and wraps. In clear mode it counts up to compare value A and then returns to zero. In the two phase-correct modes it counts up to a turning point and back down again; the turning point is 0xFF in one mode and compare value A in the other.

Each channel compares the count with its own compare value. When a tick arrives while the count equals that value, the channel sets its flag bit and drives its waveform output according to a per-channel action field. The interrupt output combines the flags with a mask register. In the phase-correct modes the compare values are double buffered: a bus write changes only a holding register, and that value becomes active only when the counter reaches its turning point. In the other two modes a write takes effect at once.

Top module: `tmr_dual_cmp`

## Requirements
- R1: After reset the count, every register, both waveform outputs and the interrupt output are 0.
- R2: The source field is CTRL bits [2:0]. The value 000 stops the count. Values 001 to 101 tick on strobe bits 0 to 4. The value 110 ticks on a falling edge and 111 on a rising edge of the external pin, each taken after a two-flop synchronizer.
- R3: In mode 00 (CTRL bits [4:3]) the counter counts up by one per tick and wraps from 0xFF to 0x00.
- R4: In mode 01 the counter counts up, and a tick taken while the count equals active compare value A loads 0x00.
- R5: In modes 10 (turning point 0xFF) and 11 (turning point at compare value A) the counter counts down after reaching the turning point and counts up after reaching 0x00. The direction reads back in CTRL bit 7 (1 means down), and any CTRL write sets it back to up.
- R6: In modes 10 and 11 a compare write updates only the holding register. That register reads back at once, and its value becomes active on a tick taken at the turning point. In modes 00 and 01 the written value is active at once.
- R7: A tick taken while the count equals channel k's active compare value sets bit k of FLAG (address 4).
- R8: Writing 1 to a FLAG bit clears it. A match in the same cycle wins over the clear.
- R9: The interrupt output is high exactly when some FLAG bit and the matching MASK bit (address 3) are both 1.
- R10: OUTCTL (address 1) bits [2k+1:2k] set channel k's action on a match. 00 holds, 01 toggles, 10 drives 0 while counting up and 1 while counting down, and 11 does the opposite.
- R11: A COUNT write (address 2) loads the count and overrides a tick in the same cycle; that cycle produces no match.
- R12: The registers sit at these addresses: CTRL 0, OUTCTL 1, COUNT 2, MASK 3, FLAG 4, compare A 5 and compare B 6. Each reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register file |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| presc_tick | input | 5 | Prescaler strobes for source values 1 to 5 |
| ext_pin | input | 1 | External count pin, asynchronous |
| wave | output | 2 | Waveform outputs, one per channel |
| irq | output | 1 | Masked interrupt request |

## Verification
Two things can happen to FLAG in the same clock edge: a channel match can set a bit while a bus write of 1 tries to clear it. The bench provokes this by parking the count on compare value A and then raising the tick strobe and the FLAG clear write in one cycle. The flag must read 1 afterwards, and the waveform must toggle as well. A second collision also gets a directed cycle: a COUNT write arriving together with a tick. There the written value must stand unchanged and no flag may be raised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        M_FREE   = 2'd0,
        M_CLR    = 2'd1,
        M_PC_MAX = 2'd2,
        M_PC_CMP = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        A_HOLD   = 2'd0,
        A_TOGGLE = 2'd1,
        A_CLR_UP = 2'd2,
        A_SET_UP = 2'd3
    } wave_act_e;

    localparam int unsigned RA_CTRL   = 0;
    localparam int unsigned RA_OUTCTL = 1;
    localparam int unsigned RA_COUNT  = 2;
    localparam int unsigned RA_MASK   = 3;
    localparam int unsigned RA_FLAG   = 4;
    localparam int unsigned RA_CMP0   = 5;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int unsigned NUM_PRE = 5,
    parameter int unsigned SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_PRE-1:0] presc,
    input  logic               ext_pin,
    output logic               tick
);
    localparam logic [SEL_W-1:0] SEL_RISE = '1;
    localparam logic [SEL_W-1:0] SEL_FALL = SEL_RISE - 1'b1;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d.s1 = ext_pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
        fall    = ~st_q.s2 & st_q.s3;
        tick    = 1'b0;
        if (sel == SEL_RISE) begin
            tick = rise;
        end else if (sel == SEL_FALL) begin
            tick = fall;
        end else begin
            for (int i = 0; i < int'(NUM_PRE); i++) begin
                if (sel == SEL_W'(i + 1)) tick = presc[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an edge tick requires the synchronized pin to have moved one cycle earlier
    p_edge_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (sel == SEL_RISE || sel == SEL_FALL)) |-> (st_q.s2 != st_q.s3));
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         dir_clr,
    output logic [W-1:0] cnt,
    output logic         down
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ld_en) begin
            c_d.cnt = ld_val;
        end else if (tick) begin
            unique case (mode)
                M_FREE: begin
                    c_d.cnt  = c_q.cnt + 1'b1;
                    c_d.down = 1'b0;
                end
                M_CLR: begin
                    c_d.cnt  = (c_q.cnt == top) ? '0 : c_q.cnt + 1'b1;
                    c_d.down = 1'b0;
                end
                default: begin
                    if (!c_q.down) begin
                        if (c_q.cnt >= top) begin
                            c_d.down = 1'b1;
                            c_d.cnt  = (c_q.cnt == '0) ? '0 : c_q.cnt - 1'b1;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                    end else if (c_q.cnt == '0) begin
                        c_d.down = 1'b0;
                        c_d.cnt  = (top == '0) ? '0 : W'(1);
                    end else begin
                        c_d.cnt = c_q.cnt - 1'b1;
                    end
                end
            endcase
        end
        if (dir_clr) c_d.down = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt  = c_q.cnt;
    assign down = c_q.down;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(cnt));

    p_clr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && mode == M_CLR && cnt == top) |=> (cnt == '0));

    p_turn_only_at_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !dir_clr && mode[1] && cnt != '0 && cnt < top) |=> $stable(down));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic         at_top,
    input  logic         down,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] buf_val,
    input  wave_act_e    act,
    output logic [W-1:0] cmp_val,
    output logic         match,
    output logic         wave
);
    typedef struct packed {
        logic [W-1:0] held;
        logic         wave;
    } chan_t;

    chan_t h_d, h_q;

    always_comb begin
        h_d     = h_q;
        cmp_val = pwm ? h_q.held : buf_val;
        match   = tick && (cnt == cmp_val);
        if (!pwm || (tick && at_top)) h_d.held = buf_val;
        if (match) begin
            unique case (act)
                A_TOGGLE: h_d.wave = ~h_q.wave;
                A_CLR_UP: h_d.wave = down;
                A_SET_UP: h_d.wave = ~down;
                default:  h_d.wave = h_q.wave;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign wave = h_q.wave;

    p_wave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(wave));

    p_held_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !(tick && at_top)) |=> (!pwm || $stable(cmp_val)));
endmodule

// File: rtl/tmr_dual_cmp.sv
module tmr_dual_cmp import tmr_pkg::*; #(
    parameter  int unsigned W       = 8,
    parameter  int unsigned NUM_CH  = 2,
    parameter  int unsigned NUM_PRE = 5,
    localparam int unsigned ADDR_W  = $clog2(RA_CMP0 + NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [W-1:0]       bus_wdata,
    output logic [W-1:0]       bus_rdata,
    input  logic [NUM_PRE-1:0] presc_tick,
    input  logic               ext_pin,
    output logic [NUM_CH-1:0]  wave,
    output logic               irq
);
    localparam int unsigned SEL_W = 3;

    typedef struct packed {
        logic [SEL_W-1:0]           cs;
        tmr_mode_e                  mode;
        logic [2*NUM_CH-1:0]        oact;
        logic [NUM_CH-1:0]          mask;
        logic [NUM_CH-1:0]          flag;
        logic [NUM_CH-1:0][W-1:0]   cmp;
    } regs_t;

    regs_t             r_d, r_q;
    logic              tick_raw, tick, cnt_wr, ctrl_wr, flag_wr, pwm, at_top, cnt_down;
    logic [W-1:0]      cnt, top_val;
    logic [W-1:0]      cmp_val [NUM_CH];
    logic [NUM_CH-1:0] match;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
    assign cnt_wr  = bus_wr && (bus_addr == ADDR_W'(RA_COUNT));
    assign flag_wr = bus_wr && (bus_addr == ADDR_W'(RA_FLAG));
    assign tick    = tick_raw & ~cnt_wr;
    assign pwm     = r_q.mode[1];
    assign top_val = (r_q.mode == M_CLR || r_q.mode == M_PC_CMP) ? cmp_val[0] : '1;
    assign at_top  = (cnt == top_val);
    assign irq     = |(r_q.flag & r_q.mask);

    tmr_tick_sel #(.NUM_PRE(NUM_PRE), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .sel(r_q.cs), .presc(presc_tick),
        .ext_pin(ext_pin), .tick(tick_raw)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(r_q.mode), .top(top_val),
        .ld_en(cnt_wr), .ld_val(bus_wdata), .dir_clr(ctrl_wr),
        .cnt(cnt), .down(cnt_down)
    );

    for (genvar k = 0; k < int'(NUM_CH); k++) begin : g_ch
        tmr_chan #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pwm(pwm), .at_top(at_top),
            .down(cnt_down), .cnt(cnt), .buf_val(r_q.cmp[k]),
            .act(wave_act_e'(r_q.oact[2*k +: 2])),
            .cmp_val(cmp_val[k]), .match(match[k]), .wave(wave[k])
        );

        p_flag_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
            match[k] |=> r_q.flag[k]);
    end

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.cs   = bus_wdata[SEL_W-1:0];
            r_d.mode = tmr_mode_e'(bus_wdata[4:3]);
        end
        if (bus_wr && bus_addr == ADDR_W'(RA_OUTCTL)) r_d.oact = bus_wdata[2*NUM_CH-1:0];
        if (bus_wr && bus_addr == ADDR_W'(RA_MASK))   r_d.mask = bus_wdata[NUM_CH-1:0];
        for (int k = 0; k < int'(NUM_CH); k++) begin
            if (bus_wr && bus_addr == ADDR_W'(RA_CMP0 + k)) r_d.cmp[k] = bus_wdata;
        end
        r_d.flag = (r_q.flag & ~(flag_wr ? bus_wdata[NUM_CH-1:0] : '0)) | match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(RA_CTRL)) begin
            bus_rdata[SEL_W-1:0] = r_q.cs;
            bus_rdata[4:3]       = r_q.mode;
            bus_rdata[W-1]       = cnt_down;
        end else if (bus_addr == ADDR_W'(RA_OUTCTL)) begin
            bus_rdata[2*NUM_CH-1:0] = r_q.oact;
        end else if (bus_addr == ADDR_W'(RA_COUNT)) begin
            bus_rdata = cnt;
        end else if (bus_addr == ADDR_W'(RA_MASK)) begin
            bus_rdata[NUM_CH-1:0] = r_q.mask;
        end else if (bus_addr == ADDR_W'(RA_FLAG)) begin
            bus_rdata[NUM_CH-1:0] = r_q.flag;
        end
        for (int k = 0; k < int'(NUM_CH); k++) begin
            if (bus_addr == ADDR_W'(RA_CMP0 + k)) bus_rdata = r_q.cmp[k];
        end
    end

    p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cs == '0 && !cnt_wr) |=> $stable(cnt));

    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq);

    p_write_beats_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(bus_wdata)));
endmodule

// File: tb/tb_tmr_dual_cmp.sv
module tb_tmr_dual_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] presc_tick = '0;
    logic       ext_pin = 1'b0;
    logic [1:0] wave;
    logic       irq;
    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_OUT = 3'd1, A_CNT = 3'd2, A_MASK = 3'd3,
                           A_FLAG = 3'd4, A_CMPA = 3'd5, A_CMPB = 3'd6;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] top;
        logic [7:0] start;
        logic [7:0] nt;
        logic [7:0] ecnt;
        logic       edn;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'h10, 8'hFE, 8'd3, 8'h01, 1'b0},
        '{2'd1, 8'h05, 8'h03, 8'd4, 8'h01, 1'b0},
        '{2'd1, 8'h05, 8'h00, 8'd6, 8'h00, 1'b0},
        '{2'd2, 8'h10, 8'hFD, 8'd4, 8'hFD, 1'b1},
        '{2'd3, 8'h04, 8'h00, 8'd6, 8'h02, 1'b1},
        '{2'd3, 8'h04, 8'h00, 8'd9, 8'h01, 1'b0}
    };

    tmr_dual_cmp dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
        .ext_pin(ext_pin), .wave(wave), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input int n);
        presc_tick[0] = 1'b1;
        repeat (n) @(negedge clk);
        presc_tick[0] = 1'b0;
    endtask

    task automatic setup_pc(input logic [1:0] mode, input logic [7:0] ta, input logic [7:0] st);
        wr(A_CTRL, 8'h00);
        wr(A_CMPA, ta);
        wr(A_CNT, st);
        wr(A_CTRL, {3'b000, mode, 3'b001});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_FLAG, v); chk("R1 flag", v, 0);
        chk("R1 wave", wave, 0);
        chk("R1 irq", irq, 0);

        // R12 register readback
        wr(A_MASK, 8'h02); rd(A_MASK, v); chk("R12 mask", v, 8'h02);
        wr(A_CMPB, 8'hA5); rd(A_CMPB, v); chk("R12 cmpB", v, 8'hA5);
        wr(A_OUT, 8'h0C);  rd(A_OUT, v);  chk("R12 outctl", v, 8'h0C);
        wr(A_MASK, 8'h00); wr(A_OUT, 8'h00);

        // R3 R4 R5 vector table
        foreach (VECS[i]) begin
            setup_pc(VECS[i].mode, VECS[i].top, VECS[i].start);
            run(int'(VECS[i].nt));
            rd(A_CNT, v);
            chk(VECS[i].mode == 2'd0 ? "R3 count" : VECS[i].mode == 2'd1 ? "R4 count" : "R5 count",
                v, VECS[i].ecnt);
            rd(A_CTRL, v);
            chk("R5 direction", v[7], VECS[i].edn);
        end

        // R2 stopped
        wr(A_CTRL, 8'h00); wr(A_CNT, 8'h20);
        run(5);
        rd(A_CNT, v); chk("R2 stopped", v, 8'h20);
        // R2 strobe select: value 3 uses strobe bit 2
        wr(A_CTRL, 8'h03);
        run(4);
        rd(A_CNT, v); chk("R2 other strobe ignored", v, 8'h20);
        presc_tick[2] = 1'b1;
        repeat (3) @(negedge clk);
        presc_tick[2] = 1'b0;
        rd(A_CNT, v); chk("R2 strobe 2", v, 8'h23);
        // R2 external rising edge
        wr(A_CTRL, 8'h07);
        ext_pin = 1'b1; repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R2 rising", v, 8'h24);
        ext_pin = 1'b0; repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R2 rising ignores fall", v, 8'h24);
        // R2 external falling edge
        wr(A_CTRL, 8'h06);
        ext_pin = 1'b1; repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R2 falling ignores rise", v, 8'h24);
        ext_pin = 1'b0; repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R2 falling", v, 8'h25);

        // R11 write beats tick, no match
        wr(A_CTRL, 8'h01); wr(A_CMPA, 8'h40); wr(A_FLAG, 8'hFF);
        @(negedge clk);
        presc_tick[0] = 1'b1; bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h40;
        @(negedge clk);
        presc_tick[0] = 1'b0; bus_wr = 1'b0;
        rd(A_CNT, v);  chk("R11 count", v, 8'h40);
        rd(A_FLAG, v); chk("R11 no match", v, 0);

        // R7 R9 R10 match, flag, toggle, mask
        wr(A_OUT, 8'h01); wr(A_CNT, 8'h3E);
        run(2);
        rd(A_FLAG, v); chk("R7 no early match", v, 0);
        run(1);
        rd(A_FLAG, v); chk("R7 flag A", v, 1);
        chk("R10 toggle", wave[0], 1);
        chk("R9 masked", irq, 0);
        wr(A_MASK, 8'h01);
        chk("R9 irq", irq, 1);
        // R8 clear by writing 1
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, v); chk("R8 clear", v, 0);
        chk("R9 irq low", irq, 0);
        // R8 match and clear in one cycle
        wr(A_CNT, 8'h40);
        @(negedge clk);
        presc_tick[0] = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h01;
        @(negedge clk);
        presc_tick[0] = 1'b0; bus_wr = 1'b0;
        rd(A_FLAG, v); chk("R8 set wins", v, 1);
        chk("R10 toggle back", wave[0], 0);

        // R6 transparent in mode 00, R10 set-up action on channel B
        wr(A_CMPB, 8'h45); wr(A_OUT, 8'h0D);
        run(4);
        chk("R10 B before match", wave[1], 0);
        run(1);
        chk("R10 set when up", wave[1], 1);
        rd(A_FLAG, v); chk("R6 transparent B", v[1], 1);

        // R6 buffered compare in mode 11
        setup_pc(2'd3, 8'h04, 8'h00);
        run(2);
        wr(A_CMPA, 8'h06);
        rd(A_CMPA, v); chk("R6 holding readback", v, 8'h06);
        run(3);
        rd(A_CNT, v);  chk("R6 old top used", v, 8'h03);
        rd(A_CTRL, v); chk("R5 turned down", v[7], 1);
        run(10);
        rd(A_CNT, v);  chk("R6 new top used", v, 8'h05);
        rd(A_CTRL, v); chk("R5 down after new top", v[7], 1);

        // R10 clear-up/set-down in phase-correct mode
        wr(A_OUT, 8'h08);
        wr(A_CTRL, 8'h00);
        wr(A_CMPB, 8'h02);
        setup_pc(2'd3, 8'h04, 8'h00);
        run(3);
        chk("R10 clear on up match", wave[1], 0);
        run(4);
        chk("R10 set on down match", wave[1], 1);
        run(4);
        chk("R10 clear again", wave[1], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule